// File: doc/BRIEF.md
# Sticky Temperature Fault Status with Interrupt Latch

This block gathers five live fault conditions from a temperature monitor: local over-limit, local under-limit, remote over-limit, remote under-limit and remote sensor open. It turns them into a readable status byte and an active-low interrupt level. Each fault condition sets its own sticky flag. A status read clears a flag only when the condition behind it has gone away. A fault that is still present keeps its flag set.

A separate interrupt latch drives the alert output. It sets whenever any flag is set. A status read does not release it. It is released only by an alert-response strobe, and only when no fault condition is live and every flag has already been cleared. A mask input holds the output high without disturbing the latch, so the alert reappears when the mask is lifted. The bus decode that produces the strobes and the comparators that produce the conditions are outside this block.

Top module: `thermal_status_alert`

## Requirements
- R1: While `rst` is high at a clock edge, every flag and the interrupt latch clear, so after that edge `status_o` is 0x00 and `alert_n_o` is 1.
- R2: `status_o` bit 7 is busy, and bits 6, 5, 4, 3, 2 carry the flags for `fault_i[4]` (local high), `fault_i[3]` (local low), `fault_i[2]` (remote high), `fault_i[1]` (remote low) and `fault_i[0]` (remote open). Bits 1 and 0 are always 0. Inputs are seen on `status_o` one clock after they are applied.
- R3: Bit 7 follows `busy_i` one cycle later and is not sticky.
- R4: A flag sets in the cycle after its fault input is 1. It stays set while no status read occurs.
- R5: A status read (`stat_rd_i` = 1) clears exactly those flags whose fault input is 0 in that cycle. A flag whose fault input is still 1 stays set.
- R6: If a status read and a newly asserted fault fall in the same cycle, the flag for that fault ends up set.
- R7: When any flag becomes set and the mask is 0, `alert_n_o` goes low in the same cycle that the flag appears on `status_o`.
- R8: A status read that clears every flag leaves `alert_n_o` low.
- R9: An alert-response strobe (`alert_ack_i` = 1) releases the latch only if, in that cycle, all of `fault_i` are 0 and all flags were already clear. The output is then high in the next cycle. Otherwise the strobe has no effect.
- R10: With `alert_mask_i` = 1, `alert_n_o` is 1 one cycle later. The latch keeps its state, and `alert_n_o` goes low again one cycle after the mask returns to 0 if the latch is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 5 | Live fault conditions: [4] local high, [3] local low, [2] remote high, [1] remote low, [0] remote open |
| busy_i | input | 1 | Conversion-in-progress level |
| stat_rd_i | input | 1 | One-cycle strobe: status byte is being read |
| alert_ack_i | input | 1 | One-cycle strobe: alert-response read by the bus master |
| alert_mask_i | input | 1 | 1 holds the alert output high |
| status_o | output | 8 | Registered status byte |
| alert_n_o | output | 1 | Registered active-low interrupt level |

## Verification
Faults are applied singly on every input position, to tell a wrong bit mapping from a missing flag. They are also applied all at once and then partly withdrawn during a read, which separates selective clearing from wholesale clearing. Reads are issued both while a fault persists and after it has dropped, and in the same cycle as a freshly rising fault, to expose a read that wins over a new fault. Alert-response strobes are placed with flags still set, in the same cycle as the clearing read, and with a fault live but no flags set, so a latch that releases early is distinguished from one that releases correctly. The mask is toggled while the latch is set, which tells a gated output apart from a cleared latch.

// File: rtl/thermal_status_pkg.sv
package thermal_status_pkg;
  localparam int unsigned NUM_FAULT = 5;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned FLAG_LSB  = STAT_W - 1 - NUM_FAULT;
  localparam int unsigned BUSY_BIT  = STAT_W - 1;
  typedef logic [NUM_FAULT-1:0] fault_vec_t;
  typedef logic [STAT_W-1:0]    status_t;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  input  logic rd_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  logic flag_q;

  // A live condition always wins over a clearing read.
  assign flag_nxt_o = cond_i | (flag_q & ~rd_i);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/alert_latch.sv
module alert_latch (
  input  logic clk,
  input  logic rst,
  input  logic any_set_i,
  input  logic release_ok_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic alert_n_o
);
  logic latch_q;
  logic latch_nxt;
  logic alert_n_q;

  assign latch_nxt = any_set_i | (latch_q & ~(ack_i & release_ok_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      latch_q   <= latch_nxt;
      alert_n_q <= ~(latch_nxt & ~mask_i);
    end
  end

  assign alert_n_o = alert_n_q;
endmodule

// File: rtl/status_pack.sv
module status_pack
  import thermal_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busy_i,
  input  fault_vec_t flags_nxt_i,
  output status_t    status_o
);
  status_t status_q;
  status_t status_d;

  always_comb begin
    status_d = '0;
    status_d[BUSY_BIT] = busy_i;
    status_d[FLAG_LSB +: NUM_FAULT] = flags_nxt_i;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/thermal_status_alert.sv
module thermal_status_alert
  import thermal_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] fault_i,
  input  logic       busy_i,
  input  logic       stat_rd_i,
  input  logic       alert_ack_i,
  input  logic       alert_mask_i,
  output logic [7:0] status_o,
  output logic       alert_n_o
);
  fault_vec_t flag_q;
  fault_vec_t flag_nxt;
  logic       release_ok;

  for (genvar g = 0; g < NUM_FAULT; g++) begin : g_flag
    sticky_flag u_flag (
      .clk        (clk),
      .rst        (rst),
      .cond_i     (fault_i[g]),
      .rd_i       (stat_rd_i),
      .flag_o     (flag_q[g]),
      .flag_nxt_o (flag_nxt[g])
    );
  end

  // Release needs every cause gone and every flag already cleared.
  assign release_ok = (fault_i == '0) && (flag_q == '0);

  alert_latch u_latch (
    .clk          (clk),
    .rst          (rst),
    .any_set_i    (|flag_nxt),
    .release_ok_i (release_ok),
    .ack_i        (alert_ack_i),
    .mask_i       (alert_mask_i),
    .alert_n_o    (alert_n_o)
  );

  status_pack u_pack (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy_i),
    .flags_nxt_i (flag_nxt),
    .status_o    (status_o)
  );
endmodule

// File: rtl/thermal_status_alert_chk.sv
module thermal_status_alert_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] fault_i,
  input logic       busy_i,
  input logic       stat_rd_i,
  input logic       alert_ack_i,
  input logic       alert_mask_i,
  input logic [7:0] status_o,
  input logic       alert_n_o
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status_o[1:0] == 2'b00);

  p_busy_live_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_o[7] == $past(busy_i));

  p_fault_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (fault_i != 5'd0) |=> ((status_o[6:2] & $past(fault_i)) == $past(fault_i)));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !stat_rd_i |=> ((status_o[6:2] & $past(status_o[6:2])) == $past(status_o[6:2])));

  p_alert_low_r7: assert property (@(posedge clk) disable iff (rst)
    (fault_i != 5'd0 && !alert_mask_i) |=> !alert_n_o);

  p_latch_held_r9: assert property (@(posedge clk) disable iff (rst)
    (!alert_n_o && !alert_ack_i && !alert_mask_i) |=> !alert_n_o);

  p_mask_high_r10: assert property (@(posedge clk) disable iff (rst)
    alert_mask_i |=> alert_n_o);
endmodule

bind thermal_status_alert thermal_status_alert_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .fault_i      (fault_i),
  .busy_i       (busy_i),
  .stat_rd_i    (stat_rd_i),
  .alert_ack_i  (alert_ack_i),
  .alert_mask_i (alert_mask_i),
  .status_o     (status_o),
  .alert_n_o    (alert_n_o)
);

// File: tb/thermal_status_alert_bench.sv
module thermal_status_alert_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] fault_i = '0;
  logic       busy_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic       alert_ack_i = 1'b0;
  logic       alert_mask_i = 1'b0;
  logic [7:0] status_o;
  logic       alert_n_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  thermal_status_alert u_thermal_status_alert (
    .clk(clk), .rst(rst), .fault_i(fault_i), .busy_i(busy_i),
    .stat_rd_i(stat_rd_i), .alert_ack_i(alert_ack_i),
    .alert_mask_i(alert_mask_i), .status_o(status_o), .alert_n_o(alert_n_o)
  );

  typedef struct packed {
    logic [4:0]  f;
    logic        b;
    logic        rd;
    logic        ack;
    logic        mask;
    logic [7:0]  st;
    logic        an;
    logic [23:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, "R2 "}, // quiet
    '{5'b10000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, "R7 "}, // local high sets, alert low
    '{5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, "R4 "}, // sticky
    '{5'b10000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h40, 1'b0, "R5 "}, // read with cause live
    '{5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R8 "}, // read clears, latch held
    '{5'b00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 "}, // ack releases
    '{5'b00001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h84, 1'b0, "R2 "}, // open + busy
    '{5'b00000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h04, 1'b1, "R3 "}, // busy drops, mask on
    '{5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 1'b0, "R10"}, // unmask, latch kept
    '{5'b00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04, 1'b0, "R9 "}, // ack with flag set
    '{5'b00000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R9 "}, // ack with clearing read
    '{5'b00100, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 1'b0, "R9 "}, // ack with fault
    '{5'b00100, 1'b0, 1'b1, 1'b1, 1'b0, 8'h10, 1'b0, "R5 "}, // read, cause live
    '{5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R8 "},
    '{5'b01000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h20, 1'b0, "R9 "}, // live fault blocks release
    '{5'b00000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R5 "},
    '{5'b00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 "},
    '{5'b11111, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFC, 1'b0, "R2 "}, // all set
    '{5'b00011, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0C, 1'b0, "R5 "}, // selective clear
    '{5'b00000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b1, "R10"},
    '{5'b00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, "R10"}, // latch survived mask
    '{5'b00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, "R9 "}
  };

  task automatic check(input logic [7:0] est, input logic ean, input logic [23:0] req);
    checks++;
    if (status_o !== est || alert_n_o !== ean) begin
      errors++;
      $display("FAIL %s: status=%02h alert_n=%b expected status=%02h alert_n=%b",
               req, status_o, alert_n_o, est, ean);
    end
  endtask

  task automatic drive(input logic [4:0] f, input logic b, input logic rd,
                       input logic ack, input logic mask);
    fault_i = f; busy_i = b; stat_rd_i = rd; alert_ack_i = ack; alert_mask_i = mask;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(8'h00, 1'b1, "R1 "); // reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].f, VEC[i].b, VEC[i].rd, VEC[i].ack, VEC[i].mask);
      check(VEC[i].st, VEC[i].an, VEC[i].req);
    end

    // R2: each fault input lands on its own status bit
    for (int k = 0; k < 5; k++) begin
      drive(5'(1 << k), 1'b0, 1'b0, 1'b0, 1'b0);
      check(8'(1 << (k + 2)), 1'b0, "R2 ");
      drive(5'b00000, 1'b0, 1'b1, 1'b0, 1'b0);
      check(8'h00, 1'b0, "R8 ");
      drive(5'b00000, 1'b0, 1'b0, 1'b1, 1'b0);
      check(8'h00, 1'b1, "R9 ");
    end

    // R6: fault rises in the same cycle as a read
    drive(5'b00010, 1'b0, 1'b1, 1'b0, 1'b0);
    check(8'h08, 1'b0, "R6 ");
    drive(5'b00000, 1'b0, 1'b0, 1'b0, 1'b0);
    check(8'h08, 1'b0, "R6 ");

    // R1: reset in mid-operation clears flags and latch
    drive(5'b10100, 1'b1, 1'b0, 1'b0, 1'b0);
    fault_i = '0; busy_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(8'h00, 1'b1, "R1 ");
    rst = 1'b0;
    drive(5'b00000, 1'b0, 1'b0, 1'b0, 1'b0);
    check(8'h00, 1'b1, "R1 ");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule